// File: doc/BRIEF.md
# Word Halving and Min/Max Execution Unit

This unit performs one of six 32-bit word operations on two source operands per issued cycle: signed maximum, signed minimum, signed halving add, signed halving subtract, unsigned halving add and unsigned halving subtract. Each halving operation works on a 33-bit intermediate, so the sum or difference is exact before it is shifted right by one bit. The unit cannot overflow and does not saturate.

The datapath width is set by a parameter and may be 32 or 64. On a 64-bit datapath only bits [31:0] of each source are read. The 32-bit word result is then sign-extended into the upper half, and this includes the unsigned halving results. Results are registered: an operation issued with `in_vld` high appears on the outputs, with `out_vld`, on the next cycle. An unused select code gives a zero result and raises an illegal-operation flag.

Top module: `wdsp_alu`

## Requirements
- R1: With `op` = 0 (signed max), `out_res` is `src_a` when `src_a` >= `src_b` as signed 32-bit words, and `src_b` otherwise.
- R2: With `op` = 1 (signed min), `out_res` is `src_b` when `src_a` >= `src_b` as signed words, and `src_a` otherwise.
- R3: With `op` = 2 (signed halving add), the result is the exact 33-bit signed sum shifted arithmetically right by one. For example, 0x40000000 and 0x80000000 give 0xE0000000, and 0x7FFFFFFF and 0x7FFFFFFF give 0x7FFFFFFF.
- R4: With `op` = 3 (signed halving subtract), the result is the exact 33-bit signed difference a-b shifted arithmetically right by one. For example, 0x7FFFFFFF and 0x80000000 give 0x7FFFFFFF, and 0x80000000 and 0x40000000 give 0xA0000000.
- R5: With `op` = 4 (unsigned halving add), the result is the 33-bit sum including the carry, shifted logically right by one. For example, 0x80000000 and 0x80000000 give 0x80000000.
- R6: With `op` = 5 (unsigned halving subtract), the result is the 33-bit difference including the borrow, shifted right by one. For example, 0x7FFFFFFF and 0x80000000 give 0xFFFFFFFF, and 0x80000000 and 0x7FFFFFFF give 0x00000000.
- R7: With `op` = 6 or 7, `out_res` is zero and `out_ill` is 1. For codes 0 to 5, `out_ill` is 0.
- R8: With XLEN = 64, bits [63:32] of the sources are ignored, and bits [63:32] of `out_res` equal bit 31 of the result, for every operation.
- R9: `out_vld` in a cycle equals `in_vld` from the previous cycle, and the result is registered at the same time. When `in_vld` is low, `out_res` and `out_ill` hold their values.
- R10: A synchronous active-high `rst` clears `out_vld`, `out_res` and `out_ill`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Issue strobe for the operands and the select |
| op | input | 3 | Operation select (0 to 5 valid) |
| src_a | input | XLEN | First operand |
| src_b | input | XLEN | Second operand |
| out_vld | output | 1 | Result valid, one cycle after issue |
| out_res | output | XLEN | Registered result |
| out_ill | output | 1 | Registered illegal-select flag |

## Verification
The bench is elaborated with XLEN = 64, and it puts junk in the upper operand halves so that any use of those bits shows up. The vectors include equal operands, operands that differ only in sign, and the extreme values 0x7FFFFFFF and 0x80000000. These separate a signed comparison from an unsigned one, the carry-keeping 33-bit arithmetic from wrapping 32-bit arithmetic, and an arithmetic shift from a logical shift. Further tests cover the sign extension of unsigned results that have bit 31 set, the illegal select codes, the hold of the outputs while `in_vld` is low, and reset in the middle of a run.

// File: rtl/wdsp_pkg.sv
package wdsp_pkg;
  localparam int WORD_W = 32;

  typedef enum logic [2:0] {
    OP_SMAX  = 3'd0,
    OP_SMIN  = 3'd1,
    OP_SHADD = 3'd2,
    OP_SHSUB = 3'd3,
    OP_UHADD = 3'd4,
    OP_UHSUB = 3'd5
  } wdsp_op_e;

  function automatic logic signed_ge(input logic [WORD_W-1:0] a, input logic [WORD_W-1:0] b);
    return $signed(a) >= $signed(b);
  endfunction

  function automatic logic [WORD_W:0] ext33(input logic [WORD_W-1:0] v, input logic sgn);
    return {sgn & v[WORD_W-1], v};
  endfunction

  function automatic logic [WORD_W-1:0] halve(input logic [WORD_W:0] v);
    return v[WORD_W:1];
  endfunction
endpackage

// File: rtl/wdsp_minmax.sv
module wdsp_minmax
  import wdsp_pkg::*;
(
  input  logic [WORD_W-1:0] a,
  input  logic [WORD_W-1:0] b,
  input  logic              sel_min,
  output logic [WORD_W-1:0] res,
  output logic              a_ge_b
);
  always_comb begin
    a_ge_b = signed_ge(a, b);
    if (sel_min) res = a_ge_b ? b : a;
    else         res = a_ge_b ? a : b;
  end

  always_comb begin
    assert_minmax_pick_R1: assert (res == a || res == b);
  end
endmodule

// File: rtl/wdsp_halver.sv
module wdsp_halver
  import wdsp_pkg::*;
(
  input  logic [WORD_W-1:0] a,
  input  logic [WORD_W-1:0] b,
  input  logic              is_sub,
  input  logic              is_signed,
  output logic [WORD_W-1:0] res,
  output logic [WORD_W:0]   wide
);
  logic [WORD_W:0] ea, eb;
  always_comb begin
    ea   = ext33(a, is_signed);
    eb   = ext33(b, is_signed);
    wide = is_sub ? (ea - eb) : (ea + eb);
    res  = halve(wide);
  end

  always_comb begin
    // R5: the unsigned sum is never below either operand
    if (!is_sub && !is_signed)
      assert_no_overflow_R5: assert (wide >= {1'b0, a});
  end
endmodule

// File: rtl/wdsp_alu.sv
module wdsp_alu
  import wdsp_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_vld,
  input  logic [2:0]      op,
  input  logic [XLEN-1:0] src_a,
  input  logic [XLEN-1:0] src_b,
  output logic            out_vld,
  output logic [XLEN-1:0] out_res,
  output logic            out_ill
);
  localparam int EXT_W = XLEN - WORD_W;

  logic [WORD_W-1:0] wa, wb, mm_res, hv_res, word_res;
  logic [WORD_W:0]   hv_wide;
  logic              mm_ge, op_ill, is_mm;
  logic [XLEN-1:0]   full_res;

  assign wa = src_a[WORD_W-1:0];
  assign wb = src_b[WORD_W-1:0];

  wdsp_minmax u_mm (
    .a(wa), .b(wb), .sel_min(op[0]), .res(mm_res), .a_ge_b(mm_ge)
  );

  wdsp_halver u_hv (
    .a(wa), .b(wb), .is_sub(op[0]), .is_signed(~op[2]),
    .res(hv_res), .wide(hv_wide)
  );

  always_comb begin
    op_ill   = (op > 3'd5);
    is_mm    = (op[2:1] == 2'b00);
    word_res = op_ill ? '0 : (is_mm ? mm_res : hv_res);
  end

  generate
    if (EXT_W > 0) begin : g_ext
      assign full_res = {{EXT_W{word_res[WORD_W-1]}}, word_res};
    end else begin : g_noext
      assign full_res = word_res;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld <= 1'b0;
      out_res <= '0;
      out_ill <= 1'b0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) begin
        out_res <= full_res;
        out_ill <= op_ill;
      end
    end
  end

  assert_vld_follows_R9: assert property (@(posedge clk) disable iff (rst)
    out_vld == $past(in_vld));
  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> $stable(out_res) && $stable(out_ill));
  assert_ill_zero_R7: assert property (@(posedge clk) disable iff (rst)
    out_ill |-> out_res == '0);
  assert_reset_R10: assert property (@(posedge clk)
    $past(rst) |-> !out_vld && !out_ill);
  generate
    if (EXT_W > 0) begin : g_sx_chk
      assert_sign_ext_R8: assert property (@(posedge clk) disable iff (rst)
        out_res[XLEN-1:WORD_W] == {EXT_W{out_res[WORD_W-1]}});
    end
  endgenerate
endmodule

// File: tb/wdsp_alu_tb.sv
module wdsp_alu_tb;
  localparam int XLEN = 64;
  logic clk = 0, rst = 1, in_vld = 0;
  logic [2:0] op = 0;
  logic [XLEN-1:0] src_a = 0, src_b = 0;
  logic out_vld, out_ill;
  logic [XLEN-1:0] out_res;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  wdsp_alu #(.XLEN(XLEN)) u_dut (.*);

  typedef struct packed { logic [2:0] op; logic [31:0] a; logic [31:0] b; logic [31:0] exp; } vec_t;
  localparam int NV = 22;
  localparam vec_t VEC [NV] = '{
    '{3'd0, 32'h00000005, 32'hFFFFFFFB, 32'h00000005},
    '{3'd0, 32'h80000000, 32'h7FFFFFFF, 32'h7FFFFFFF},
    '{3'd0, 32'h12345678, 32'h12345678, 32'h12345678},
    '{3'd1, 32'h00000005, 32'hFFFFFFFB, 32'hFFFFFFFB},
    '{3'd1, 32'h80000000, 32'h7FFFFFFF, 32'h80000000},
    '{3'd1, 32'h00000001, 32'h00000002, 32'h00000001},
    '{3'd2, 32'h40000000, 32'h80000000, 32'hE0000000},
    '{3'd2, 32'h7FFFFFFF, 32'h7FFFFFFF, 32'h7FFFFFFF},
    '{3'd2, 32'h80000000, 32'h80000000, 32'h80000000},
    '{3'd2, 32'hFFFFFFFF, 32'h00000000, 32'hFFFFFFFF},
    '{3'd3, 32'h7FFFFFFF, 32'h80000000, 32'h7FFFFFFF},
    '{3'd3, 32'h80000000, 32'h7FFFFFFF, 32'h80000000},
    '{3'd3, 32'h80000000, 32'h40000000, 32'hA0000000},
    '{3'd4, 32'h80000000, 32'h80000000, 32'h80000000},
    '{3'd4, 32'h40000000, 32'h80000000, 32'h60000000},
    '{3'd4, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF},
    '{3'd5, 32'h7FFFFFFF, 32'h80000000, 32'hFFFFFFFF},
    '{3'd5, 32'h80000000, 32'h7FFFFFFF, 32'h00000000},
    '{3'd5, 32'h80000000, 32'h40000000, 32'h20000000},
    '{3'd6, 32'h11111111, 32'h22222222, 32'h00000000},
    '{3'd7, 32'hFFFFFFFF, 32'h00000001, 32'h00000000},
    '{3'd4, 32'h00000003, 32'h00000002, 32'h00000002}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic string rtag(input logic [2:0] o);
    case (o)
      3'd0: return "R1"; 3'd1: return "R2"; 3'd2: return "R3";
      3'd3: return "R4"; 3'd4: return "R5"; 3'd5: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic issue(input logic [2:0] o, input logic [31:0] a, input logic [31:0] b, input logic [31:0] junk);
    @(negedge clk);
    in_vld = 1; op = o; src_a = {junk, a}; src_b = {~junk, b};
    @(negedge clk);
    in_vld = 0;
  endtask

  initial begin
    #1000000;
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 reset vld", {63'd0, out_vld}, 64'd0);
    chk("R10 reset res", out_res, 64'd0);
    rst = 0;
    for (int i = 0; i < NV; i++) begin
      logic [63:0] e;
      issue(VEC[i].op, VEC[i].a, VEC[i].b, 32'hA5A5_0000 + i);
      e = {{32{VEC[i].exp[31]}}, VEC[i].exp};
      chk({rtag(VEC[i].op), " R8 res"}, out_res, e);
      chk({rtag(VEC[i].op), " R7 ill"}, {63'd0, out_ill}, {63'd0, VEC[i].op > 3'd5});
      chk("R9 vld", {63'd0, out_vld}, 64'd1);
    end
    // R8: unsigned result with bit 31 set must sign-extend
    issue(3'd5, 32'h00000000, 32'h00000002, 32'h0);
    chk("R8 unsigned sx", out_res, 64'hFFFFFFFF_FFFFFFFF);
    // R9: hold while idle
    @(negedge clk);
    src_a = 64'h5; src_b = 64'h9; op = 3'd0;
    @(negedge clk);
    chk("R9 vld low", {63'd0, out_vld}, 64'd0);
    chk("R9 hold", out_res, 64'hFFFFFFFF_FFFFFFFF);
    // R10: mid-run reset
    issue(3'd0, 32'h7, 32'h1, 32'h0);
    chk("R1 pre-reset", out_res, 64'h7);
    @(negedge clk); rst = 1; @(negedge clk); rst = 0;
    chk("R10 mid res", out_res, 64'd0);
    chk("R10 mid vld", {63'd0, out_vld}, 64'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule